// File: doc/BRIEF.md
# Serial Page Programming Target Engine

This block is the device-side engine of a four-wire serial programming port. While the active-low programming reset pin is held low, the block takes over the clock, data-in and data-out pins. It accepts fixed 32-bit instructions and serves them from an internal flash model, a page buffer and a small set of fuse bytes. The block runs on the system clock and finds the edges of the serial clock by oversampling it. For that reason the serial clock may run at no more than a quarter of the system clock.

A host first holds the programming reset low for a settling period. It then sends the unlock instruction and proceeds with the work: it erases the part, fills the page buffer byte by byte, commits pages, reads bytes back, sets fuses, and polls until erases and page commits have finished. Releasing the programming reset ends the session. Flash, fuses and the page buffer keep their contents when the session ends.

Top module: `serial_page_programmer`

## Requirements
- R1: The port becomes active only after `prog_reset_n` has been low for `HOLD_CYCLES` consecutive system clocks. Serial clock edges seen before that are discarded. `miso` is 0 whenever the port is not active.
- R2: An instruction is 32 bits, sent MSB first as four bytes in this order: opcode, address-high, address-low, data. `mosi` is taken on each rising `sck` edge, and `miso` changes only after a rising edge has been detected. `sck` must not exceed clk/4.
- R3: While the port is active, `miso` returns 0x00 during bytes one and two. During byte three it returns the byte received in slot two, and during byte four it returns the instruction's reply byte.
- R4: The unlock instruction is opcode 0xAC with 0x53 in slot two. Until it has been received, no other instruction has any effect, and every reply byte is 0x00. Unknown opcodes reply 0x00 and have no effect.
- R5: Opcode 0x40 writes the slot-four byte into page buffer entry ({hi,lo} mod PAGE_BYTES). Flash is left unchanged. The buffer resets to 0xFF.
- R6: Opcode 0x4C copies the whole page buffer into flash page (({hi,lo} mod flash size) / PAGE_BYTES).
- R7: Opcode 0x20 replies with flash byte ({hi,lo} mod PAGE_BYTES*FLASH_PAGES). It replies 0x00 while the read-disable flag is set.
- R8: Opcode 0xA0 writes fuse (lo mod FUSE_COUNT) with the slot-four byte, and opcode 0x50 reads it. Fuses reset to 0xFF and survive chip erase.
- R9: Opcode 0xC0 sets every flash byte to 0xFF and clears the read-disable flag. Opcode 0xE0 sets that flag, and opcode 0x58 replies with it in bit 0.
- R10: Opcode 0xF0 replies with busy in bit 0. Busy lasts `ERASE_CYCLES` after an erase and `WRITE_CYCLES` after a page commit. While busy, every instruction other than a read has no effect.
- R11: Raising `prog_reset_n` ends the session, and the unlock must be repeated afterwards. Flash, fuses and the page buffer are retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| prog_reset_n | input | 1 | Active-low programming request pin (asynchronous) |
| sck | input | 1 | Serial clock from the host, at most clk/4 |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
The hardest state to reach is an instruction that arrives while a page commit is still busy. The bench has to prove from the pins alone that such a load was dropped. To do this, it sends a page load right behind a commit and its poll, so that the load completes inside the `WRITE_CYCLES` window. After the busy time has passed, it commits the same buffer to a second page, and the stale buffer byte then shows up on a flash read. The settling rule is reached the same way: a full unlock frame is clocked inside the hold window, and the bench then shows that fuse reads still return 0x00.

// File: rtl/spiprog_pkg.sv
// Shared constants and types for the serial page programmer.
// Assumes: instructions are four bytes, sent MSB first.
package spiprog_pkg;
    localparam int FRAME_BITS = 32;
    localparam int BYTE_BITS  = 8;

    localparam logic [7:0] OP_UNLOCK   = 8'hAC;
    localparam logic [7:0] UNLOCK_KEY  = 8'h53;
    localparam logic [7:0] OP_ERASE    = 8'hC0;
    localparam logic [7:0] OP_LOAD     = 8'h40;
    localparam logic [7:0] OP_COMMIT   = 8'h4C;
    localparam logic [7:0] OP_RD_FLASH = 8'h20;
    localparam logic [7:0] OP_RD_FUSE  = 8'h50;
    localparam logic [7:0] OP_WR_FUSE  = 8'hA0;
    localparam logic [7:0] OP_SET_LOCK = 8'hE0;
    localparam logic [7:0] OP_RD_LOCK  = 8'h58;
    localparam logic [7:0] OP_POLL     = 8'hF0;

    typedef struct packed {
        logic [7:0] op;
        logic [7:0] hi;
        logic [7:0] lo;
        logic [7:0] dat;
    } frame_t;
endpackage

// File: rtl/pin_sync.sv
// Brings the asynchronous port pins into the clk domain and detects rising sck.
// Assumes: sck is at most clk/4, and mosi is stable around the rising sck edge.
module pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic mosi,
    input  logic prog_reset_n,
    output logic sck_rise,
    output logic mosi_s,
    output logic tgt_low
);
    logic [SYNC_STAGES-1:0] sck_m;
    logic [SYNC_STAGES-1:0] mosi_m;
    logic [SYNC_STAGES-1:0] req_m;
    logic                   sck_q;

    // Synchronizer chains plus one delayed sck copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_m  <= '0;
            mosi_m <= '0;
            req_m  <= '1;
            sck_q  <= 1'b0;
        end else begin
            sck_m  <= {sck_m[SYNC_STAGES-2:0], sck};
            mosi_m <= {mosi_m[SYNC_STAGES-2:0], mosi};
            req_m  <= {req_m[SYNC_STAGES-2:0], prog_reset_n};
            sck_q  <= sck_m[SYNC_STAGES-1];
        end
    end

    assign sck_rise = sck_m[SYNC_STAGES-1] & ~sck_q;
    assign mosi_s   = mosi_m[SYNC_STAGES-1];
    assign tgt_low  = ~req_m[SYNC_STAGES-1];
endmodule

// File: rtl/entry_gate.sv
// Opens the port once the request pin has been low for HOLD_CYCLES clocks.
// Assumes: tgt_low is already synchronized.
module entry_gate #(
    parameter int HOLD_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgt_low,
    output logic ready
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);

    logic [CW-1:0] hold_cnt;

    // Saturating count of consecutive low cycles on the request pin.
    always_ff @(posedge clk) begin
        if (!rst_n || !tgt_low) begin
            hold_cnt <= '0;
        end else if (hold_cnt != CW'(HOLD_CYCLES)) begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    assign ready = tgt_low && (hold_cnt == CW'(HOLD_CYCLES));
endmodule

// File: rtl/frame_shifter.sv
// Assembles 32-bit instructions from mosi and drives the miso reply stream.
// Assumes: reply is valid in the cycle of the rise that ends byte three.
module frame_shifter
    import spiprog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ready,
    input  logic        sck_rise,
    input  logic        mosi_s,
    input  logic [7:0]  reply,
    output logic [23:0] peek,
    output logic        frame_done,
    output frame_t      frame,
    output logic        miso
);
    localparam int CNT_W    = $clog2(FRAME_BITS);
    localparam int ECHO_AT  = 2 * BYTE_BITS - 1;
    localparam int REPLY_AT = 3 * BYTE_BITS - 1;
    localparam int LAST_AT  = FRAME_BITS - 1;

    logic [CNT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-1:0] rx_sh;
    logic [FRAME_BITS-1:0] rx_next;
    logic [BYTE_BITS-1:0]  tx_sh;

    assign rx_next = {rx_sh[FRAME_BITS-2:0], mosi_s};
    assign peek    = rx_next[23:0];

    // Bit counting, receive shifting and transmit loading on each detected rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            frame_done <= 1'b0;
        end else if (!ready) begin
            bit_cnt    <= '0;
            tx_sh      <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= sck_rise && (bit_cnt == CNT_W'(LAST_AT));
            if (sck_rise) begin
                bit_cnt <= bit_cnt + 1'b1;
                rx_sh   <= rx_next;
                if (bit_cnt == CNT_W'(ECHO_AT)) begin
                    tx_sh <= rx_next[7:0];
                end else if (bit_cnt == CNT_W'(REPLY_AT)) begin
                    tx_sh <= reply;
                end else begin
                    tx_sh <= {tx_sh[BYTE_BITS-2:0], 1'b0};
                end
            end
        end
    end

    assign frame = frame_t'(rx_sh);
    assign miso  = tx_sh[BYTE_BITS-1];
endmodule

// File: rtl/prog_core.sv
// Executes instructions: unlock, page buffer, flash pages, fuses, lock flag, busy timer.
// Assumes: PAGE_BYTES, FLASH_PAGES and FUSE_COUNT are powers of two, each at least 2;
//          flash size is at most 64 KiB.
module prog_core
    import spiprog_pkg::*;
#(
    parameter int PAGE_BYTES   = 128,
    parameter int FLASH_PAGES  = 8,
    parameter int FUSE_COUNT   = 4,
    parameter int ERASE_CYCLES = 1200,
    parameter int WRITE_CYCLES = 800
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tgt_low,
    input  logic        frame_done,
    input  frame_t      frame,
    input  logic [23:0] peek,
    output logic [7:0]  reply,
    output logic        enabled,
    output logic        busy
);
    localparam int FLASH_BYTES = PAGE_BYTES * FLASH_PAGES;
    localparam int AW          = $clog2(FLASH_BYTES);
    localparam int OW          = $clog2(PAGE_BYTES);
    localparam int PW          = AW - OW;
    localparam int FW          = $clog2(FUSE_COUNT);
    localparam int MAX_BUSY    = (ERASE_CYCLES > WRITE_CYCLES) ? ERASE_CYCLES : WRITE_CYCLES;
    localparam int BW          = $clog2(MAX_BUSY + 1);

    logic [7:0]    pbuf  [PAGE_BYTES];
    logic [7:0]    fuses [FUSE_COUNT];
    logic          lock_q;
    logic [BW-1:0] busy_cnt;
    logic [FLASH_PAGES-1:0][7:0] page_rd;

    logic [AW-1:0] wr_addr, rd_addr;
    logic          exec, do_erase, do_commit;
    logic          unused_hi;

    assign wr_addr   = AW'({frame.hi, frame.lo});
    assign rd_addr   = AW'(peek[15:0]);
    assign busy      = (busy_cnt != '0);
    assign exec      = frame_done && enabled && !busy;
    assign do_erase  = exec && (frame.op == OP_ERASE);
    assign do_commit = exec && (frame.op == OP_COMMIT);
    assign unused_hi = ^{frame.hi, peek[15:8]};

    // Control state: unlock, page buffer, fuses, lock flag and busy timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enabled  <= 1'b0;
            lock_q   <= 1'b0;
            busy_cnt <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
            for (int i = 0; i < FUSE_COUNT; i++) fuses[i] <= 8'hFF;
        end else begin
            if (busy) busy_cnt <= busy_cnt - 1'b1;
            if (!tgt_low) begin
                enabled <= 1'b0;
            end else if (frame_done && !enabled &&
                         frame.op == OP_UNLOCK && frame.hi == UNLOCK_KEY) begin
                enabled <= 1'b1;
            end
            if (exec) begin
                case (frame.op)
                    OP_ERASE: begin
                        lock_q   <= 1'b0;
                        busy_cnt <= BW'(ERASE_CYCLES);
                    end
                    OP_COMMIT:   busy_cnt <= BW'(WRITE_CYCLES);
                    OP_LOAD:     pbuf[wr_addr[OW-1:0]] <= frame.dat;
                    OP_WR_FUSE:  fuses[frame.lo[FW-1:0]] <= frame.dat;
                    OP_SET_LOCK: lock_q <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // One storage block per flash page, each with its own erase and commit path.
    for (genvar p = 0; p < FLASH_PAGES; p++) begin : g_page
        logic [7:0] cells [PAGE_BYTES];

        // Page contents: reset and erase fill with 0xFF, commit copies the buffer.
        always_ff @(posedge clk) begin
            if (!rst_n || do_erase) begin
                for (int i = 0; i < PAGE_BYTES; i++) cells[i] <= 8'hFF;
            end else if (do_commit && wr_addr[AW-1:OW] == PW'(p)) begin
                for (int i = 0; i < PAGE_BYTES; i++) cells[i] <= pbuf[i];
            end
        end

        assign page_rd[p] = cells[rd_addr[OW-1:0]];
    end

    // Reply byte for the fourth slot, chosen from the header received so far.
    always_comb begin
        reply = 8'h00;
        if (enabled) begin
            case (peek[23:16])
                OP_RD_FLASH: reply = lock_q ? 8'h00 : page_rd[rd_addr[AW-1:OW]];
                OP_RD_FUSE:  reply = fuses[peek[FW-1:0]];
                OP_RD_LOCK:  reply = {7'b0, lock_q};
                OP_POLL:     reply = {7'b0, busy};
                default:     reply = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/serial_page_programmer.sv
// Top: serial programming target engine with a page-buffered flash model.
// Assumes: sck is at most clk/4; prog_reset_n, sck and mosi are asynchronous to clk.
module serial_page_programmer #(
    parameter int PAGE_BYTES   = 128,
    parameter int FLASH_PAGES  = 8,
    parameter int FUSE_COUNT   = 4,
    parameter int HOLD_CYCLES  = 400,
    parameter int ERASE_CYCLES = 1200,
    parameter int WRITE_CYCLES = 800,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_reset_n,
    input  logic sck,
    input  logic mosi,
    output logic miso
);
    logic                 sck_rise, mosi_s, tgt_low, ready;
    logic                 frame_done, enabled, busy;
    logic [7:0]           reply;
    logic [23:0]          peek;
    spiprog_pkg::frame_t  frame;

    pin_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi),
        .prog_reset_n(prog_reset_n), .sck_rise(sck_rise),
        .mosi_s(mosi_s), .tgt_low(tgt_low)
    );

    entry_gate #(.HOLD_CYCLES(HOLD_CYCLES)) i_gate (
        .clk(clk), .rst_n(rst_n), .tgt_low(tgt_low), .ready(ready)
    );

    frame_shifter i_shift (
        .clk(clk), .rst_n(rst_n), .ready(ready), .sck_rise(sck_rise),
        .mosi_s(mosi_s), .reply(reply), .peek(peek),
        .frame_done(frame_done), .frame(frame), .miso(miso)
    );

    prog_core #(
        .PAGE_BYTES(PAGE_BYTES), .FLASH_PAGES(FLASH_PAGES),
        .FUSE_COUNT(FUSE_COUNT), .ERASE_CYCLES(ERASE_CYCLES),
        .WRITE_CYCLES(WRITE_CYCLES)
    ) i_core (
        .clk(clk), .rst_n(rst_n), .tgt_low(tgt_low),
        .frame_done(frame_done), .frame(frame), .peek(peek),
        .reply(reply), .enabled(enabled), .busy(busy)
    );
endmodule

// File: rtl/serial_page_programmer_chk.sv
// Property checker for serial_page_programmer, attached through bind.
// Assumes: the internal signals named in the bind exist in the top module.
module serial_page_programmer_chk (
    input logic clk,
    input logic rst_n,
    input logic ready,
    input logic tgt_low,
    input logic sck_rise,
    input logic miso,
    input logic frame_done,
    input logic enabled,
    input logic busy
);
    // R1
    miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> !miso);

    // R2
    miso_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso) |-> ($past(sck_rise) || !$past(ready)));

    // R4
    unlock_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enabled) |-> $past(frame_done));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(frame_done) && $past(enabled)));

    // R11
    unlock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(enabled) |-> !$past(tgt_low));
endmodule

bind serial_page_programmer serial_page_programmer_chk i_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .tgt_low(tgt_low),
    .sck_rise(sck_rise), .miso(miso), .frame_done(frame_done),
    .enabled(enabled), .busy(busy)
);

// File: tb/test_serial_page_programmer.sv
// Self-checking bench with a behavioural model of the programming engine.
module test_serial_page_programmer;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 4;
    localparam int PAGE       = 128;
    localparam int PAGES      = 8;
    localparam int FUSES      = 4;
    localparam int HOLD       = 400;
    localparam int SETTLE     = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_reset_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso;

    int n_checks = 0;
    int n_fail = 0;
    int quiet = 0;
    bit done = 1'b0;

    // behavioural model state
    byte unsigned flash_m [PAGE*PAGES];
    byte unsigned pbuf_m  [PAGE];
    byte unsigned fuse_m  [FUSES];
    bit lock_m = 0, en_m = 0, busy_m = 0, active_m = 0;

    serial_page_programmer i_serial_page_programmer (
        .clk(clk), .rst_n(rst_n), .prog_reset_n(prog_reset_n),
        .sck(sck), .mosi(mosi), .miso(miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // R1: count cycles with the request pin released; miso must be low then.
    always @(posedge clk) quiet <= prog_reset_n ? quiet + 1 : 0;
    always @(negedge clk) begin
        if (rst_n && quiet >= 4) check8("R1 idle miso", {7'b0, miso}, 8'h00);
    end

    function automatic logic [7:0] model_reply(input logic [7:0] op, hi, lo);
        int a;
        a = {hi, lo} % (PAGE*PAGES);
        if (!en_m) return 8'h00;
        case (op)
            8'h20: return lock_m ? 8'h00 : flash_m[a];
            8'h50: return fuse_m[lo % FUSES];
            8'h58: return {7'b0, lock_m};
            8'hF0: return {7'b0, busy_m};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_exec(input logic [7:0] op, hi, lo, dat);
        int a;
        a = {hi, lo} % (PAGE*PAGES);
        if (!active_m) return;
        if (!en_m) begin
            if (op == 8'hAC && hi == 8'h53) en_m = 1;
            return;
        end
        if (busy_m) return;
        case (op)
            8'hC0: begin
                foreach (flash_m[i]) flash_m[i] = 8'hFF;
                lock_m = 0; busy_m = 1;
            end
            8'h4C: begin
                for (int i = 0; i < PAGE; i++) flash_m[(a / PAGE) * PAGE + i] = pbuf_m[i];
                busy_m = 1;
            end
            8'h40: pbuf_m[a % PAGE] = dat;
            8'hA0: fuse_m[lo % FUSES] = dat;
            8'hE0: lock_m = 1;
            default: ;
        endcase
    endtask

    task automatic xfer_byte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            mosi = b[i];
            repeat (HALF_SCK) @(negedge clk);
            r[i] = miso;
            sck = 1'b1;
            repeat (HALF_SCK) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    // One instruction: compare all four reply bytes with the model, then update it.
    task automatic instr(input string tag, input logic [7:0] op, hi, lo, dat);
        logic [7:0] r1, r2, r3, r4, e4;
        e4 = active_m ? model_reply(op, hi, lo) : 8'h00;
        xfer_byte(op, r1);
        xfer_byte(hi, r2);
        xfer_byte(lo, r3);
        xfer_byte(dat, r4);
        check8("R3 leading bytes", r1 | r2, 8'h00);
        check8("R3 echo", r3, active_m ? hi : 8'h00);
        check8(tag, r4, e4);
        repeat (4) @(negedge clk);
        model_exec(op, hi, lo, dat);
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
        busy_m = 0;
    endtask

    task automatic enter(input bit wait_hold);
        prog_reset_n = 1'b0;
        active_m = 0;
        if (wait_hold) begin
            repeat (HOLD + 8) @(negedge clk);
            active_m = 1;
        end
    endtask

    task automatic leave();
        prog_reset_n = 1'b1;
        active_m = 0;
        en_m = 0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        foreach (flash_m[i]) flash_m[i] = 8'hFF;
        foreach (pbuf_m[i]) pbuf_m[i] = 8'hFF;
        foreach (fuse_m[i]) fuse_m[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check8("R1 reset state miso", {7'b0, miso}, 8'h00);

        // R1: a full unlock clocked inside the hold window is discarded
        enter(1'b0);
        instr("R1 frame in hold window", 8'hAC, 8'h53, 8'h00, 8'h00);
        repeat (HOLD) @(negedge clk);
        active_m = 1;
        // R4: still locked, so fuse read gives 0 and fuse write is ignored
        instr("R4 read before unlock", 8'h50, 8'h00, 8'h00, 8'h00);
        instr("R4 write before unlock", 8'hA0, 8'h00, 8'h01, 8'h3C);
        instr("R4 unlock", 8'hAC, 8'h53, 8'h00, 8'h00);
        instr("R4 unknown opcode", 8'h77, 8'h12, 8'h34, 8'h56);

        // R8: fuses
        instr("R8 write fuse 2", 8'hA0, 8'h00, 8'h02, 8'h5A);
        instr("R8 read fuse 2", 8'h50, 8'h00, 8'h02, 8'h00);
        instr("R8 fuse 1 untouched", 8'h50, 8'h00, 8'h01, 8'h00);
        instr("R8 index wraps", 8'h50, 8'h00, 8'h06, 8'h00);

        // R5 / R6: page buffer loads and commit
        instr("R7 blank read", 8'h20, 8'h00, 8'h10, 8'h00);
        instr("R5 load 0", 8'h40, 8'h00, 8'h00, 8'h11);
        instr("R5 load 5", 8'h40, 8'h00, 8'h05, 8'h22);
        instr("R5 load 127", 8'h40, 8'h00, 8'h7F, 8'h33);
        instr("R5 load wraps offset", 8'h40, 8'h7F, 8'h03, 8'h44);
        instr("R5 flash unchanged by load", 8'h20, 8'h01, 8'h83, 8'h00);
        instr("R6 commit page 1", 8'h4C, 8'h00, 8'h80, 8'h00);
        instr("R10 poll busy after commit", 8'hF0, 8'h00, 8'h00, 8'h00);
        instr("R10 load while busy", 8'h40, 8'h00, 8'h05, 8'h99);
        settle();
        instr("R10 poll idle", 8'hF0, 8'h00, 8'h00, 8'h00);
        instr("R6 read 0x80", 8'h20, 8'h00, 8'h80, 8'h00);
        instr("R6 read 0x85", 8'h20, 8'h00, 8'h85, 8'h00);
        instr("R6 read 0xFF", 8'h20, 8'h00, 8'hFF, 8'h00);
        instr("R6 read 0x81", 8'h20, 8'h00, 8'h81, 8'h00);
        instr("R6 page 0 untouched", 8'h20, 8'h00, 8'h05, 8'h00);
        instr("R6 commit page 2", 8'h4C, 8'h01, 8'h00, 8'h00);
        settle();
        instr("R10 busy load was dropped", 8'h20, 8'h01, 8'h05, 8'h00);
        instr("R6 commit page 3", 8'h4C, 8'h01, 8'h80, 8'h00);
        settle();
        instr("R5 wrapped offset landed", 8'h20, 8'h01, 8'h83, 8'h00);
        instr("R7 address wraps", 8'h20, 8'h04, 8'h85, 8'h00);

        // R9: read-disable flag and chip erase
        instr("R9 set lock", 8'hE0, 8'h00, 8'h00, 8'h00);
        instr("R7 read blocked", 8'h20, 8'h00, 8'h80, 8'h00);
        instr("R9 lock flag set", 8'h58, 8'h00, 8'h00, 8'h00);
        instr("R9 erase", 8'hC0, 8'h00, 8'h00, 8'h00);
        instr("R10 poll busy after erase", 8'hF0, 8'h00, 8'h00, 8'h00);
        settle();
        instr("R10 poll idle after erase", 8'hF0, 8'h00, 8'h00, 8'h00);
        instr("R9 lock cleared", 8'h58, 8'h00, 8'h00, 8'h00);
        instr("R9 flash erased", 8'h20, 8'h00, 8'h80, 8'h00);
        instr("R8 fuse survives erase", 8'h50, 8'h00, 8'h02, 8'h00);

        // R11: session end and re-entry
        leave();
        enter(1'b1);
        instr("R11 relocked after release", 8'h50, 8'h00, 8'h02, 8'h00);
        instr("R11 unlock again", 8'hAC, 8'h53, 8'h00, 8'h00);
        instr("R11 fuse retained", 8'h50, 8'h00, 8'h02, 8'h00);
        instr("R11 commit retained buffer", 8'h4C, 8'h00, 8'h00, 8'h00);
        settle();
        instr("R11 buffer retained", 8'h20, 8'h00, 8'h05, 8'h00);
        leave();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule